// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides a double-width dividend by a single-width divisor over several clock cycles, producing one quotient bit per cycle. The partial remainder lives in one double-width register. Each cycle the register is shifted left by one through its write-back wiring, and the divisor is trial-subtracted from its upper half. The new quotient bit enters at the low end. After W steps the upper half holds the remainder and the lower half holds the quotient.

A signed mode treats both operands as two's complement. In this mode the block divides their magnitudes and then corrects the signs: the quotient truncates toward zero, and the remainder takes the sign of the dividend. A zero divisor is caught when the operands are accepted, and so is any dividend whose upper half is too large for the quotient to fit in W bits. In both of these cases the block reports at once and does no iteration. In signed mode a quotient magnitude that fits in W bits but not in the signed range is reported when the iterations end.

Operands enter through a valid/ready handshake. `in_ready` is high exactly when the block is idle, and a beat is taken on a clock edge where `in_valid` and `in_ready` are both high. The result side has no back-pressure: `out_valid` is a one-cycle pulse, and the result and flag outputs keep their values until the next result is produced.

Top module: `seq_divider`

## Requirements
- R1: While idle the block drives `in_ready` high and `busy` low. An accepted beat with a nonzero divisor and no early overflow keeps `busy` high for exactly W cycles, with `in_ready` low during that time.
- R2: In unsigned mode a valid result satisfies dividend = quotient*divisor + remainder, with remainder < divisor. `out_valid` is high in the cycle after the (W+1)-th clock edge counted from the accepting edge.
- R3: `out_valid` is high for a single cycle. `quotient`, `remainder`, `div_zero` and `ovf` hold their values until the next result.
- R4: A divisor of zero sets `div_zero` with `ovf` low and quotient = remainder = 0. `out_valid` is high in the cycle after the accepting edge.
- R5: In unsigned mode, if dividend bits [2W-1:W] are greater than or equal to the divisor, `ovf` is set with quotient = remainder = 0. `out_valid` is high in the cycle after the accepting edge.
- R6: In signed mode (`is_signed`=1, both operands two's complement), the quotient is the true quotient truncated toward zero. The remainder is zero or has the sign of the dividend.
- R7: In signed mode `ovf` is set with quotient = remainder = 0 when the quotient does not fit in W-bit two's complement. If the upper half of the dividend magnitude is at least the divisor magnitude, this is reported after one edge. Otherwise it is reported after W+1 edges.
- R8: A beat offered while `busy` is high is not accepted and has no effect on the result in progress.
- R9: `div_zero` and `ovf` are never high together, and both are low for a valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Block can take a beat (idle) |
| dividend | input | 2W | Dividend |
| divisor | input | W | Divisor |
| is_signed | input | 1 | 1 = two's complement operands |
| busy | output | 1 | Iterations in progress |
| out_valid | output | 1 | One-cycle result pulse |
| quotient | output | W | Quotient |
| remainder | output | W | Remainder |
| div_zero | output | 1 | Divisor was zero |
| ovf | output | 1 | Quotient does not fit |

## Verification
Two latencies apply, both counted from the edge that accepts a beat. A zero divisor or an early overflow gives a result in the cycle after that edge. Every other case, including a late signed overflow, gives a result after W+1 edges. For each vector the bench derives the expected latency and steps the clock edge by edge, sampling on falling edges. It checks that `out_valid` stays low until the due cycle, then compares every output in exactly that cycle and checks that the pulse has dropped one cycle later.

// File: rtl/seq_divider_pkg.sv
package seq_divider_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/sdiv_operand_prep.sv
module sdiv_operand_prep #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           is_signed,
  output logic [2*W-1:0] z_mag,
  output logic [W-1:0]   x_mag,
  output logic           z_neg,
  output logic           x_neg,
  output logic           zero_div,
  output logic           early_ovf
);
  always_comb begin
    z_neg     = is_signed & dividend[2*W-1];
    x_neg     = is_signed & divisor[W-1];
    z_mag     = z_neg ? (~dividend + 1'b1) : dividend;
    x_mag     = x_neg ? (~divisor + 1'b1) : divisor;
    zero_div  = (divisor == '0);
    // quotient magnitude cannot fit in W bits when the top half already covers the divisor
    early_ovf = !zero_div && (z_mag[2*W-1:W] >= x_mag);
  end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] pr_in,
  input  logic [W-1:0]   dsor,
  output logic [2*W-1:0] pr_out,
  output logic           qbit
);
  logic          lost_msb;
  logic [W-1:0]  upper;
  logic [W:0]    trial;

  always_comb begin
    lost_msb = pr_in[2*W-1];
    upper    = pr_in[2*W-2:W-1];
    trial    = {1'b0, upper} - {1'b0, dsor};
    // difference non-negative when a bit was shifted out or no borrow occurred
    qbit     = lost_msb | ~trial[W];
    pr_out   = {(qbit ? trial[W-1:0] : upper), pr_in[W-2:0], qbit};
  end
endmodule

// File: rtl/sdiv_sign_fix.sv
module sdiv_sign_fix #(
  parameter int W = 32
) (
  input  logic [2*W-1:0] pr_final,
  input  logic           z_neg,
  input  logic           x_neg,
  input  logic           is_signed,
  output logic [W-1:0]   q_out,
  output logic [W-1:0]   r_out,
  output logic           late_ovf
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] q_mag;
  logic [W-1:0] r_mag;
  logic         q_neg;

  always_comb begin
    q_mag    = pr_final[W-1:0];
    r_mag    = pr_final[2*W-1:W];
    q_neg    = z_neg ^ x_neg;
    late_ovf = is_signed && (q_neg ? (q_mag > MOST_NEG) : q_mag[W-1]);
    if (late_ovf) begin
      q_out = '0;
      r_out = '0;
    end else begin
      q_out = q_neg ? (~q_mag + 1'b1) : q_mag;
      r_out = z_neg ? (~r_mag + 1'b1) : r_mag;
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import seq_divider_pkg::*;
#(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           is_signed,
  output logic           busy,
  output logic           out_valid,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           div_zero,
  output logic           ovf
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

  phase_t         phase;
  logic [CW-1:0]  step_cnt;
  logic [2*W-1:0] pr_q;
  logic [W-1:0]   dsor_q;
  logic           zneg_q, xneg_q, sgn_q;

  logic [2*W-1:0] z_mag;
  logic [W-1:0]   x_mag;
  logic           z_neg, x_neg, zero_div, early_ovf;
  logic [2*W-1:0] pr_next;
  logic           qbit;
  logic [W-1:0]   q_fix, r_fix;
  logic           late_ovf;
  logic           take;

  sdiv_operand_prep #(.W(W)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .is_signed(is_signed),
    .z_mag    (z_mag),
    .x_mag    (x_mag),
    .z_neg    (z_neg),
    .x_neg    (x_neg),
    .zero_div (zero_div),
    .early_ovf(early_ovf)
  );

  sdiv_step #(.W(W)) u_step (
    .pr_in (pr_q),
    .dsor  (dsor_q),
    .pr_out(pr_next),
    .qbit  (qbit)
  );

  sdiv_sign_fix #(.W(W)) u_fix (
    .pr_final (pr_next),
    .z_neg    (zneg_q),
    .x_neg    (xneg_q),
    .is_signed(sgn_q),
    .q_out    (q_fix),
    .r_out    (r_fix),
    .late_ovf (late_ovf)
  );

  assign busy     = (phase == PH_RUN);
  assign in_ready = (phase == PH_IDLE);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      step_cnt  <= '0;
      pr_q      <= '0;
      dsor_q    <= '0;
      zneg_q    <= 1'b0;
      xneg_q    <= 1'b0;
      sgn_q     <= 1'b0;
      out_valid <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        if (zero_div || early_ovf) begin
          out_valid <= 1'b1;
          quotient  <= '0;
          remainder <= '0;
          div_zero  <= zero_div;
          ovf       <= early_ovf;
        end else begin
          phase    <= PH_RUN;
          step_cnt <= '0;
          pr_q     <= z_mag;
          dsor_q   <= x_mag;
          zneg_q   <= z_neg;
          xneg_q   <= x_neg;
          sgn_q    <= is_signed;
        end
      end else if (phase == PH_RUN) begin
        pr_q     <= pr_next;
        step_cnt <= step_cnt + 1'b1;
        if (step_cnt == LAST_STEP) begin
          phase     <= PH_IDLE;
          out_valid <= 1'b1;
          quotient  <= q_fix;
          remainder <= r_fix;
          div_zero  <= 1'b0;
          ovf       <= late_ovf;
        end
      end
    end
  end
endmodule

// File: rtl/seq_divider_checker.sv
module seq_divider_checker #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [2*W-1:0] dividend,
  input logic [W-1:0]   divisor,
  input logic           is_signed,
  input logic           busy,
  input logic           out_valid,
  input logic [W-1:0]   quotient,
  input logic [W-1:0]   remainder,
  input logic           div_zero,
  input logic           ovf
);
  int unsigned    run_cnt;
  logic [2*W-1:0] cap_z;
  logic [W-1:0]   cap_x;
  logic           cap_s;
  logic [2*W-1:0] u_sum, s_sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= 0;
      cap_z   <= '0;
      cap_x   <= '0;
      cap_s   <= 1'b0;
    end else begin
      run_cnt <= busy ? run_cnt + 1 : 0;
      if (in_valid && in_ready) begin
        cap_z <= dividend;
        cap_x <= divisor;
        cap_s <= is_signed;
      end
    end
  end

  always_comb begin
    u_sum = {{W{1'b0}}, quotient} * {{W{1'b0}}, cap_x} + {{W{1'b0}}, remainder};
    s_sum = {{W{quotient[W-1]}}, quotient} * {{W{cap_x[W-1]}}, cap_x}
          + {{W{remainder[W-1]}}, remainder};
  end

  assert_busy_length_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == W) && out_valid);

  assert_unsigned_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_s && !div_zero && !ovf) |-> (u_sum == cap_z) && (remainder < cap_x));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(in_valid && in_ready)) |=> !out_valid);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(quotient) && $stable(remainder) && $stable(div_zero) && $stable(ovf));

  assert_zero_on_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (div_zero || ovf)) |-> (quotient == '0) && (remainder == '0));

  assert_signed_identity_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cap_s && !div_zero && !ovf) |->
      (s_sum == cap_z) && ((remainder == '0) || (remainder[W-1] == cap_z[2*W-1])));

  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_zero && ovf));
endmodule

bind seq_divider seq_divider_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .dividend(dividend), .divisor(divisor), .is_signed(is_signed), .busy(busy),
  .out_valid(out_valid), .quotient(quotient), .remainder(remainder),
  .div_zero(div_zero), .ovf(ovf)
);

// File: tb/sim_seq_divider.sv
module sim_seq_divider;
  localparam int BW = 32;

  typedef struct packed {
    logic          sg;
    logic [63:0]   z;
    logic [31:0]   x;
    logic [31:0]   q;
    logic [31:0]   r;
    logic          dz;
    logic          ov;
    logic          fast;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'd100,                  32'd7,          32'd14,         32'd2,          1'b0, 1'b0, 1'b0}, // R2
    '{1'b0, 64'h0000_0000_FFFF_FFFF, 32'd1,          32'hFFFF_FFFF, 32'd0,          1'b0, 1'b0, 1'b0}, // R2
    '{1'b0, 64'h0000_0001_0000_0000, 32'd2,          32'h8000_0000, 32'd0,          1'b0, 1'b0, 1'b0}, // R2
    '{1'b0, 64'hFFFF_FFFE_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0}, // R2 shifted-out msb
    '{1'b0, 64'd0,                    32'd5,          32'd0,          32'd0,          1'b0, 1'b0, 1'b0}, // R2
    '{1'b1, 64'd5,                    32'd3,          32'd1,          32'd2,          1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 64'd5,                    32'hFFFF_FFFD, 32'hFFFF_FFFF, 32'd2,          1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 32'd3,          32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 32'hFFFF_FFFD, 32'd1,          32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFF9, 32'd2,          32'hFFFF_FFFD, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 64'hFFFF_FFFF_8000_0000, 32'd1,          32'h8000_0000, 32'd0,          1'b0, 1'b0, 1'b0}, // R6 most negative
    '{1'b1, 64'd5,                    32'h8000_0000, 32'd0,          32'd5,          1'b0, 1'b0, 1'b0}, // R6
    '{1'b1, 64'h0000_0000_8000_0000, 32'd1,          32'd0,          32'd0,          1'b0, 1'b1, 1'b0}, // R7 late
    '{1'b1, 64'hFFFF_FF00_0000_0000, 32'd2,          32'd0,          32'd0,          1'b0, 1'b1, 1'b1}, // R7 early
    '{1'b0, 64'h0000_0007_0000_0000, 32'd7,          32'd0,          32'd0,          1'b0, 1'b1, 1'b1}, // R5
    '{1'b0, 64'd123,                  32'd0,          32'd0,          32'd0,          1'b1, 1'b0, 1'b1}, // R4
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 32'd0,          32'd0,          32'd0,          1'b1, 1'b0, 1'b1}  // R4 signed
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [2*BW-1:0]  dividend = '0;
  logic [BW-1:0]    divisor = '0;
  logic             is_signed = 1'b0;
  logic             busy, out_valid, div_zero, ovf;
  logic [BW-1:0]    quotient, remainder;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  seq_divider #(.W(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .is_signed(is_signed), .busy(busy),
    .out_valid(out_valid), .quotient(quotient), .remainder(remainder),
    .div_zero(div_zero), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.dz) return "R4";
    if (v.ov && !v.sg) return "R5";
    if (v.ov) return "R7";
    if (v.sg) return "R6";
    return "R2";
  endfunction

  // Offer one beat, then walk to the due cycle and compare there.
  task automatic run_vec(input vec_t v);
    int due;
    bit early;
    string tg;
    tg = tag_of(v);
    due = v.fast ? 1 : BW + 1;
    @(negedge clk);
    in_valid = 1'b1; dividend = v.z; divisor = v.x; is_signed = v.sg;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    early = 1'b0;
    for (int k = 1; k < due; k++) begin
      if (out_valid) early = 1'b1;
      if (!busy) early = 1'b1; // R1 busy throughout the run
      @(posedge clk);
      @(negedge clk);
    end
    check(!early, {tg, " R1 latency"}, early, 0);
    check(out_valid && quotient == v.q && remainder == v.r && div_zero == v.dz && ovf == v.ov,
          {tg, " result"}, {out_valid, quotient, remainder, div_zero, ovf},
          {1'b1, v.q, v.r, v.dz, v.ov});
    @(negedge clk);
    check(!out_valid && quotient == v.q && remainder == v.r, "R3 pulse/hold",
          {out_valid, quotient, remainder}, {1'b0, v.q, v.r});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready && !busy && !out_valid && quotient == 0 && remainder == 0 && !div_zero && !ovf,
          "R1 reset", {in_ready, busy, out_valid, quotient, remainder, div_zero, ovf},
          {1'b1, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R8: a beat offered mid-run is ignored
    @(negedge clk);
    in_valid = 1'b1; dividend = 64'd1000; divisor = 32'd10; is_signed = 1'b0;
    @(posedge clk);
    @(negedge clk);
    dividend = 64'd77; divisor = 32'd0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!in_ready && busy, "R8 ready low while busy", {in_ready, busy}, {1'b0, 1'b1});
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    check(quotient == 32'd100 && remainder == 0 && !div_zero && !ovf, "R8 mid-run beat ignored",
          {quotient, remainder, div_zero, ovf}, {32'd100, 32'd0, 1'b0, 1'b0});
    // R9 flags clear on valid result
    check(!div_zero && !ovf, "R9 flags", {div_zero, ovf}, 0);

    // R3 hold across idle cycles
    repeat (6) @(negedge clk);
    check(!out_valid && quotient == 32'd100 && remainder == 0 && in_ready, "R3 long hold",
          {out_valid, quotient, remainder, in_ready}, {1'b0, 32'd100, 32'd0, 1'b1});

    // R9 back-to-back: error after a zero-divide clears the other flag
    run_vec(VECS[15]);
    run_vec(VECS[14]);
    check(!div_zero && ovf, "R9 exclusive", {div_zero, ovf}, {1'b0, 1'b1});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule